// File: doc/BRIEF.md
# Password-Protected GPIO Bank Register File

This block is a memory-mapped register file that controls up to eight banks of 32 general-purpose pins. Each pin owns a small control word whose lowest bit picks its direction; each bank offers an output status view, an input status view and two write-one strobes that raise or lower output bits. Pins are numbered globally: bank = pin >> 5, bit within bank = pin & 31.

Every bank is guarded by its own write lock. A bank leaves the locked state only through a two-write ritual. First, the key value 0x00A5A501 goes to the global key register. Then, on the very next bus write, the unlock code (all zeros) goes to that bank's lock word. Writing all ones the same way relocks it. While a bank is locked, every write aimed at its registers is dropped without a trace. Reads are never restricted. Input pad levels cross into the clock domain through a two-flop synchronizer before they can be read.

The bus is a single-cycle port: one access per enabled cycle, byte addresses with the two low bits ignored, and read data returned from a register.

Top module: `gpio_locked_bank_regs`

## Requirements
- R1: While reset is held and after it is released, every bank is locked (lock word reads 0xFFFFFFFF), every output bit is 0, and every control word is 0x01 (input), so pad_oe is all zero.
- R2: The key register is at 0x520 and the key is 0x00A5A501. The lock word of bank b is at 0x500+4*b. A write to it changes the lock only if the bus write just before it was the correct key: 0x00000000 unlocks, 0xFFFFFFFF locks, and any other value leaves the lock as it was. Without the key, a lock write is ignored.
- R3: Any bus write other than a correct key write cancels an armed key. This includes a wrong key value, a lock write and a write to any other address. Reads and idle cycles leave an armed key in place.
- R4: The control word of pin p is at 0x100+4*p and holds 8 bits; the upper bits read as zero. Bit 0 = 1 makes the pin an input, 0 an output, and pad_oe[p] is the inverse of bit 0.
- R5: Writing ones to output-set (0x040+4*b) sets those output bits, and writing ones to output-clear (0x060+4*b) clears them. Zero bits leave the outputs unchanged. Output status (0x000+4*b) reads the current outputs, which drive pad_out.
- R6: While bank b is locked, writes to its output-set, output-clear and control words are ignored.
- R7: Input status (0x020+4*b) returns pad_in of bank b through a two-flop synchronizer, so a read at an edge returns the level sampled two edges earlier.
- R8: A read returns its data on bus_rdata after the access edge, and bus_rdata holds until the next read. Reads work on locked banks. Unmapped addresses, the key register, and banks at or above NUM_BANKS read as zero, and writes to those banks have no effect.
- R9: Writes to output-status and input-status addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32*NUM_BANKS | Pad input levels, pin p at bit p |
| pad_out | output | 32*NUM_BANKS | Output register values |
| pad_oe | output | 32*NUM_BANKS | Output enable, 1 = pin drives |

## Verification
Writes take effect at the edge that samples them, so pad_out, pad_oe and the lock state are due right after that edge. Read data is due on bus_rdata after the read's own edge. Input status returns the pad level seen two edges before the read edge. The bench applies each access before an edge and updates its model at that edge, keeping pad history in a short queue for the synchronizer delay. It compares all three outputs 5 ns after every edge, and it also runs directed reads whose expected values are written down by hand.

// File: rtl/gpio_regs_pkg.sv
// Package: shared address map, codes and region type for the locked
// GPIO bank register file. Assumes a 12-bit byte address space.
package gpio_regs_pkg;
    localparam int ADDR_W        = 12;
    localparam int DATA_W        = 32;
    localparam int PINS_PER_BANK = 32;
    localparam int BIT_IDX_W     = 5;
    localparam int BANK_IDX_W    = 3;
    localparam int MAX_BANKS     = 8;

    localparam logic [DATA_W-1:0] KEY_VALUE   = 32'h00A5_A501;
    localparam logic [DATA_W-1:0] LOCK_CODE   = 32'hFFFF_FFFF;
    localparam logic [DATA_W-1:0] UNLOCK_CODE = 32'h0000_0000;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_OUT_STAT,
        RG_IN_STAT,
        RG_OUT_SET,
        RG_OUT_CLR,
        RG_CTRL,
        RG_LOCK,
        RG_KEY
    } region_e;
endpackage

// File: rtl/gpio_addr_decode.sv
// Address decoder: maps a word address onto a register region, a bank
// and a bit index. Assumes word-aligned access (byte bits stripped by the
// caller). Banks at or above NUM_BANKS decode to RG_NONE.
module gpio_addr_decode
    import gpio_regs_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic [ADDR_W-3:0]     word_addr,
    output region_e               dec_region,
    output logic [BANK_IDX_W-1:0] dec_bank,
    output logic [BIT_IDX_W-1:0]  dec_bit
);
    localparam logic [BANK_IDX_W:0] NB_LIMIT = (BANK_IDX_W+1)'(NUM_BANKS);

    logic [3:0] hi;
    logic [2:0] mid;
    logic [2:0] lo;
    logic [7:0] pin_idx;
    region_e    raw_region;
    logic [BANK_IDX_W-1:0] raw_bank;

    assign hi  = word_addr[9:6];
    assign mid = word_addr[5:3];
    assign lo  = word_addr[2:0];
    assign pin_idx = {2'(hi - 4'd1), word_addr[5:0]};

    // Purpose: classify the address into a region and pick bank/bit.
    always_comb begin
        raw_region = RG_NONE;
        raw_bank   = lo;
        dec_bit    = '0;
        if (hi == 4'd0) begin
            unique case (mid)
                3'd0:    raw_region = RG_OUT_STAT;
                3'd1:    raw_region = RG_IN_STAT;
                3'd2:    raw_region = RG_OUT_SET;
                3'd3:    raw_region = RG_OUT_CLR;
                default: raw_region = RG_NONE;
            endcase
        end else if (hi >= 4'd1 && hi <= 4'd4) begin
            raw_region = RG_CTRL;
            raw_bank   = pin_idx[7:5];
            dec_bit    = pin_idx[4:0];
        end else if (hi == 4'd5 && mid == 3'd0) begin
            raw_region = RG_LOCK;
        end else if (hi == 4'd5 && mid == 3'd1 && lo == 3'd0) begin
            raw_region = RG_KEY;
        end
    end

    // Purpose: drop accesses aimed at banks that are not built.
    always_comb begin
        dec_region = raw_region;
        dec_bank   = raw_bank;
        if (raw_region != RG_NONE && raw_region != RG_KEY &&
            {1'b0, raw_bank} >= NB_LIMIT) begin
            dec_region = RG_NONE;
        end
    end
endmodule

// File: rtl/gpio_key_lock.sv
// Key and per-bank lock state. A correct key write arms the key; the
// next write consumes it. A lock-word write applies only while armed.
// Assumes wr_en is a single-cycle write strobe from the bus.
module gpio_key_lock
    import gpio_regs_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  region_e               dec_region,
    input  logic [BANK_IDX_W-1:0] dec_bank,
    input  logic [DATA_W-1:0]     wdata,
    output logic [NUM_BANKS-1:0]  locked,
    output logic                  key_armed
);
    logic key_hit;
    logic lock_hit;

    assign key_hit  = (dec_region == RG_KEY) && (wdata == KEY_VALUE);
    assign lock_hit = wr_en && key_armed && (dec_region == RG_LOCK);

    // Purpose: arm on a correct key write, disarm on any other write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_armed <= 1'b0;
        end else if (wr_en) begin
            key_armed <= key_hit;
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lock
        // Purpose: per-bank lock bit, changed only by an armed lock write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                locked[b] <= 1'b1;
            end else if (lock_hit && dec_bank == BANK_IDX_W'(b)) begin
                if (wdata == LOCK_CODE) begin
                    locked[b] <= 1'b1;
                end else if (wdata == UNLOCK_CODE) begin
                    locked[b] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/gpio_bank.sv
// One bank of 32 pins: output register with set/clear strobes, per-pin
// control words, input synchronizer and this bank's read data. Writes
// are dropped while the bank is locked. Read data is zero unless the
// decoded bank equals BANK_ID.
module gpio_bank
    import gpio_regs_pkg::*;
#(
    parameter int BANK_ID = 0,
    parameter int CTRL_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  region_e                  dec_region,
    input  logic [BANK_IDX_W-1:0]    dec_bank,
    input  logic [BIT_IDX_W-1:0]     dec_bit,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     locked,
    input  logic [PINS_PER_BANK-1:0] pad_in,
    output logic [PINS_PER_BANK-1:0] pad_out,
    output logic [PINS_PER_BANK-1:0] pad_oe,
    output logic [DATA_W-1:0]        rd_data
);
    localparam logic [CTRL_W-1:0] CTRL_RESET = CTRL_W'(1);

    logic                     sel;
    logic                     wr_ok;
    logic [PINS_PER_BANK-1:0] out_q;
    logic [PINS_PER_BANK-1:0] sync1_q;
    logic [PINS_PER_BANK-1:0] sync2_q;
    logic [CTRL_W-1:0]        ctrl_q [PINS_PER_BANK];

    assign sel   = (dec_bank == BANK_IDX_W'(BANK_ID));
    assign wr_ok = wr_en && sel && !locked;

    // Purpose: output register driven by the set and clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (wr_ok && dec_region == RG_OUT_SET) begin
            out_q <= out_q | wdata[PINS_PER_BANK-1:0];
        end else if (wr_ok && dec_region == RG_OUT_CLR) begin
            out_q <= out_q & ~wdata[PINS_PER_BANK-1:0];
        end
    end

    // Purpose: per-pin control words, reset to input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PINS_PER_BANK; i++) begin
                ctrl_q[i] <= CTRL_RESET;
            end
        end else if (wr_ok && dec_region == RG_CTRL) begin
            ctrl_q[dec_bit] <= wdata[CTRL_W-1:0];
        end
    end

    // Purpose: two-flop synchronizer for the pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= pad_in;
            sync2_q <= sync1_q;
        end
    end

    // Purpose: direction bit of each control word drives the enable.
    always_comb begin
        for (int i = 0; i < PINS_PER_BANK; i++) begin
            pad_oe[i] = ~ctrl_q[i][0];
        end
    end

    assign pad_out = out_q;

    // Purpose: this bank's contribution to the read mux.
    always_comb begin
        rd_data = '0;
        if (sel) begin
            unique case (dec_region)
                RG_OUT_STAT: rd_data = out_q;
                RG_IN_STAT:  rd_data = sync2_q;
                RG_CTRL:     rd_data = DATA_W'(ctrl_q[dec_bit]);
                RG_LOCK:     rd_data = locked ? LOCK_CODE : UNLOCK_CODE;
                default:     rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_locked_bank_regs.sv
// Top: memory-mapped GPIO register file with password-gated per-bank
// write locks. One access per bus_en cycle; read data registered and
// held until the next read. Assumes 1 <= NUM_BANKS <= 8.
module gpio_locked_bank_regs
    import gpio_regs_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int CTRL_W    = 8,
    localparam int NPINS    = NUM_BANKS * PINS_PER_BANK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);
    logic                  wr_en;
    logic                  rd_en;
    region_e               dec_region;
    logic [BANK_IDX_W-1:0] dec_bank;
    logic [BIT_IDX_W-1:0]  dec_bit;
    logic [NUM_BANKS-1:0]  bank_locked;
    logic                  key_armed;
    logic [DATA_W-1:0]     bank_rd [NUM_BANKS];
    logic [DATA_W-1:0]     rd_any;
    logic                  unused_addr_lsb;

    assign wr_en = bus_en && bus_we;
    assign rd_en = bus_en && !bus_we;
    assign unused_addr_lsb = ^bus_addr[1:0];

    gpio_addr_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .word_addr  (bus_addr[ADDR_W-1:2]),
        .dec_region (dec_region),
        .dec_bank   (dec_bank),
        .dec_bit    (dec_bit)
    );

    gpio_key_lock #(.NUM_BANKS(NUM_BANKS)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .dec_region (dec_region),
        .dec_bank   (dec_bank),
        .wdata      (bus_wdata),
        .locked     (bank_locked),
        .key_armed  (key_armed)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_bank #(.BANK_ID(b), .CTRL_W(CTRL_W)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_en),
            .dec_region (dec_region),
            .dec_bank   (dec_bank),
            .dec_bit    (dec_bit),
            .wdata      (bus_wdata),
            .locked     (bank_locked[b]),
            .pad_in     (pad_in[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .pad_out    (pad_out[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .pad_oe     (pad_oe[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .rd_data    (bank_rd[b])
        );
    end

    // Purpose: merge bank read data; unselected banks return zero.
    always_comb begin
        rd_any = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            rd_any = rd_any | bank_rd[b];
        end
    end

    // Purpose: register read data on a read, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_en) begin
            bus_rdata <= rd_any;
        end
    end
endmodule

// File: rtl/gpio_regs_chk.sv
// Checker: temporal properties of the locked GPIO register file, bound
// to the top. Observes ports plus the lock vector and key flag.
module gpio_regs_chk
    import gpio_regs_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int NPINS    = NUM_BANKS * PINS_PER_BANK
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_en,
    input logic             bus_we,
    input logic [11:0]      bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic [NUM_BANKS-1:0] locked,
    input logic             key_armed
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pad_out == '0 && pad_oe == '0 && (&locked)));

    // R2
    lock_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked != $past(locked)) |-> $past(key_armed));

    // R3
    key_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && !(bus_addr[11:2] == 10'h148 && bus_wdata == KEY_VALUE))
        |=> !key_armed);

    // R6
    locked_out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&locked) |=> $stable(pad_out));

    // R6
    locked_dir_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&locked) |=> $stable(pad_oe));

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && !bus_we) |=> $stable(bus_rdata));
endmodule

bind gpio_locked_bank_regs gpio_regs_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .locked    (bank_locked),
    .key_armed (key_armed)
);

// File: tb/gpio_locked_bank_regs_tb.sv
// Bench: behavioural model updated at each edge, compared 5 ns after it.
module gpio_locked_bank_regs_tb;
    localparam int NB = 4;
    localparam int NP = NB * 32;
    localparam int KEY_ADDR = 'h520;
    localparam logic [31:0] KEY = 32'h00A5A501;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0;
    logic          bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;

    always #10 clk = ~clk;

    gpio_locked_bank_regs #(.NUM_BANKS(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";

    bit [31:0]   m_out  [8];
    bit [7:0]    m_ctrl [256];
    bit          m_lock [8];
    bit          m_armed;
    bit [31:0]   m_rdata;
    logic [NP-1:0] hist [$];

    function automatic void m_reset();
        for (int b = 0; b < 8; b++) begin m_out[b] = 0; m_lock[b] = 1; end
        for (int p = 0; p < 256; p++) m_ctrl[p] = 8'h01;
        m_armed = 0;
        m_rdata = 0;
        hist.delete();
        for (int i = 0; i < 3; i++) hist.push_back('0);
    endfunction

    function automatic bit [31:0] m_read(int a);
        int b;
        if (a < 'h20) begin b = a / 4; return (b < NB) ? m_out[b] : 0; end
        if (a < 'h40) begin b = (a - 'h20) / 4; return (b < NB) ? hist[0][b*32 +: 32] : 0; end
        if (a >= 'h100 && a < 'h500) begin
            b = (a - 'h100) / 128;
            return (b < NB) ? {24'd0, m_ctrl[(a - 'h100) / 4]} : 0;
        end
        if (a >= 'h500 && a < 'h520) begin
            b = (a - 'h500) / 4;
            return (b < NB) ? (m_lock[b] ? 32'hFFFFFFFF : 32'h0) : 0;
        end
        return 0;
    endfunction

    function automatic void m_write(int a, bit [31:0] d);
        int b;
        bit armed_before = m_armed;
        m_armed = (a == KEY_ADDR) && (d == KEY);
        if (a >= 'h500 && a < 'h520) begin
            b = (a - 'h500) / 4;
            if (b < NB && armed_before) begin
                if (d == 32'hFFFFFFFF) m_lock[b] = 1;
                else if (d == 0) m_lock[b] = 0;
            end
        end else if (a >= 'h40 && a < 'h60) begin
            b = (a - 'h40) / 4;
            if (b < NB && !m_lock[b]) m_out[b] = m_out[b] | d;
        end else if (a >= 'h60 && a < 'h80) begin
            b = (a - 'h60) / 4;
            if (b < NB && !m_lock[b]) m_out[b] = m_out[b] & ~d;
        end else if (a >= 'h100 && a < 'h500) begin
            b = (a - 'h100) / 128;
            if (b < NB && !m_lock[b]) m_ctrl[(a - 'h100) / 4] = d[7:0];
        end
    endfunction

    task automatic check(string req, string what, logic [NP-1:0] got, logic [NP-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s got %h exp %h", req, what, got, exp);
        end
    endtask

    task automatic compare_all();
        logic [NP-1:0] e_out, e_oe;
        for (int b = 0; b < NB; b++) e_out[b*32 +: 32] = m_out[b];
        for (int p = 0; p < NP; p++) e_oe[p] = ~m_ctrl[p][0];
        check(cur_req, "pad_out", pad_out, e_out);
        check(cur_req, "pad_oe", pad_oe, e_oe);
        check(cur_req, "bus_rdata", NP'(bus_rdata), NP'(m_rdata));
    endtask

    // One bus cycle: drive, model the edge, compare 5 ns later.
    task automatic cyc(bit en, bit we, int a, bit [31:0] d);
        bus_en = en; bus_we = we; bus_addr = 12'(a); bus_wdata = d;
        @(posedge clk);
        hist.push_back(pad_in);
        void'(hist.pop_front());
        if (!rst_n) m_reset();
        else if (en && we) m_write(a, d);
        else if (en) m_rdata = m_read(a);
        #5;
        if (rst_n) compare_all();
        bus_en = 0;
    endtask

    task automatic wr(int a, bit [31:0] d); cyc(1, 1, a, d); endtask
    task automatic idle(); cyc(0, 0, 0, 0); endtask
    task automatic rd_expect(int a, bit [31:0] exp, string req);
        cyc(1, 0, a, 0);
        check(req, "directed read", NP'(bus_rdata), NP'(exp));
    endtask
    task automatic unlock(int b); wr(KEY_ADDR, KEY); wr('h500 + 4*b, 0); endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog expired during %s", cur_req);
        finish_run();
    end

    initial begin
        m_reset();
        for (int i = 0; i < 3; i++) idle();
        rst_n = 1;
        // R1: reset state
        cur_req = "R1";
        idle();
        rd_expect('h500, 32'hFFFFFFFF, "R1");
        rd_expect('h50C, 32'hFFFFFFFF, "R1");
        rd_expect('h100, 32'h1, "R1");
        rd_expect('h100 + 4*127, 32'h1, "R1");
        rd_expect('h000, 32'h0, "R1");
        check("R1", "pad_oe reset", pad_oe, '0);
        // R6: locked bank ignores set and control writes
        cur_req = "R6";
        wr('h040, 32'h0000FFFF);
        wr('h100 + 4*3, 32'h0);
        rd_expect('h000, 32'h0, "R6");
        rd_expect('h100 + 4*3, 32'h1, "R6");
        // R2: lock write without key ignored, with key applied
        cur_req = "R2";
        wr('h500, 32'h0);
        rd_expect('h500, 32'hFFFFFFFF, "R2");
        unlock(0);
        rd_expect('h500, 32'h0, "R2");
        // R3: cancelling an armed key
        cur_req = "R3";
        wr(KEY_ADDR, KEY); wr('h044, 32'h1); wr('h504, 32'h0);
        rd_expect('h504, 32'hFFFFFFFF, "R3");
        wr(KEY_ADDR, 32'h00A5A500); wr('h504, 32'h0);
        rd_expect('h504, 32'hFFFFFFFF, "R3");
        wr(KEY_ADDR, KEY); cyc(1, 0, 'h000, 0); idle(); wr('h504, 32'h0);
        rd_expect('h504, 32'h0, "R3");
        cur_req = "R2";
        wr(KEY_ADDR, KEY); wr('h508, 32'h12345678);
        rd_expect('h508, 32'hFFFFFFFF, "R2");
        // R5: set and clear strobes
        cur_req = "R5";
        wr('h040, 32'hA5A50F0F);
        wr('h060, 32'h00000F00);
        rd_expect('h000, 32'hA5A5000F, "R5");
        wr('h040, 32'h0); wr('h060, 32'h0);
        rd_expect('h000, 32'hA5A5000F, "R5");
        check("R5", "pad_out bank0", pad_out[31:0], 32'hA5A5000F);
        // R4: control words and direction
        cur_req = "R4";
        wr('h100 + 4*2, 32'h0);
        check("R4", "pad_oe pin2", NP'(pad_oe[2]), NP'(1));
        wr('h100 + 4*7, 32'hFFFFFFFF);
        rd_expect('h100 + 4*7, 32'h000000FF, "R4");
        wr('h100 + 4*40, 32'h1A);
        rd_expect('h100 + 4*40, 32'h1A, "R4");
        check("R4", "pad_oe pin40", NP'(pad_oe[40]), NP'(1));
        // R9: status addresses are read-only
        cur_req = "R9";
        wr('h000, 32'hFFFFFFFF); wr('h020, 32'hFFFFFFFF);
        rd_expect('h000, 32'hA5A5000F, "R9");
        // R7: synchronized input status
        cur_req = "R7";
        pad_in = '0; pad_in[31:0] = 32'hCAFE0001; pad_in[63:32] = 32'h0BAD0F00;
        idle(); idle(); idle();
        rd_expect('h020, 32'hCAFE0001, "R7");
        rd_expect('h024, 32'h0BAD0F00, "R7");
        pad_in[31:0] = 32'h12345678;
        cyc(1, 0, 'h020, 0); cyc(1, 0, 'h020, 0); cyc(1, 0, 'h020, 0);
        check("R7", "in status after 2 edges", NP'(bus_rdata), NP'(32'h12345678));
        // R8: unmapped, key and absent banks read zero; rdata holds
        cur_req = "R8";
        rd_expect('h080, 32'h0, "R8");
        rd_expect(KEY_ADDR, 32'h0, "R8");
        rd_expect('h014, 32'h0, "R8");
        rd_expect('h100 + 4*200, 32'h0, "R8");
        wr('h054, 32'hFFFFFFFF);
        rd_expect('h514, 32'h0, "R8");
        rd_expect('h500, 32'h0, "R8");
        idle(); idle();
        check("R8", "rdata held", NP'(bus_rdata), NP'(0));
        // R2 and R6: relock bank 0, then writes drop
        cur_req = "R2";
        wr(KEY_ADDR, KEY); wr('h500, 32'hFFFFFFFF);
        rd_expect('h500, 32'hFFFFFFFF, "R2");
        cur_req = "R6";
        wr('h060, 32'hFFFFFFFF);
        rd_expect('h000, 32'hA5A5000F, "R6");
        // Mixed random traffic against the model
        cur_req = "random mix";
        for (int i = 0; i < 600; i++) begin
            int kind = $urandom_range(0, 9);
            int b = $urandom_range(0, 5);
            pad_in = {$urandom, $urandom, $urandom, $urandom};
            case (kind)
                0, 1: wr(KEY_ADDR, ($urandom_range(0, 5) == 0) ? 32'h1 : KEY);
                2: wr('h500 + 4*b, ($urandom_range(0, 1) == 1) ? 32'h0 : 32'hFFFFFFFF);
                3: wr('h040 + 4*b, $urandom);
                4: wr('h060 + 4*b, $urandom);
                5: wr('h100 + 4*$urandom_range(0, 255), $urandom);
                6: cyc(1, 0, 4*$urandom_range(0, 'h14F), 0);
                7: cyc(1, 0, 'h020 + 4*b, 0);
                8: cyc(1, 0, 'h100 + 4*$urandom_range(0, 255), 0);
                default: idle();
            endcase
        end
        finish_run();
    end
endmodule